// File: doc/BRIEF.md
# Pixel Pack and Expand Unit

This is a registered SIMD formatting datapath for a graphics pipeline. It takes two 64-bit operands and a scale factor, and performs one of five operations. Three pack operations turn signed fixed-point lanes into saturated bytes or saturated 16-bit values. The expand operation widens bytes into fixed-point lanes. The merge operation interleaves the bytes of two operands.

The issuing logic presents the operands, an operation code and the scale, then pulses the input valid. The result appears one clock later with a matching output valid. The result stays on the output until the next accepted operation. The scale is supplied on a port by whoever holds the graphics status state.

Top module: `pxf_format_unit`

## Requirements
- R1: An active-low asynchronous reset drives `res_o` to zero and `vld_o` to 0 immediately, and they stay there while reset is held.
- R2: When `vld_i` is high at a rising clock edge, `vld_o` is high after that edge and `res_o` is the result for the operands, operation and scale sampled at that edge. `vld_o` is low after an edge where `vld_i` was low.
- R3: After an edge where `vld_i` is low, `res_o` keeps its previous value, whatever the other inputs do.
- R4: The `op_i` codes are:
  - 0: 16-bit pack.
  - 1: 32-bit pack.
  - 2: fixed 16-bit pack.
  - 3: expand.
  - 4: merge.
  - Codes 5, 6 and 7 produce an all-zero result.
- R5: 16-bit pack uses only `scale_i[3:0]`.
  - Each signed 16-bit lane i of `rs2_i` (bits 16i+15..16i) is shifted left by that scale, then arithmetically shifted right by 7.
  - The value is clamped to 0..255 and written to byte i (bits 8i+7..8i).
  - Bits 63:32 are zero.
- R6: 32-bit pack starts from `rs1_i` shifted left by 8, with bytes 0 and 4 cleared.
  - Each signed 32-bit half h of `rs2_i` is shifted left by the 5-bit scale, then arithmetically shifted right by 23.
  - The value is clamped to 0..255 and placed in byte 4h.
- R7: Fixed pack shifts each signed 32-bit half h of `rs2_i` left by the 5-bit scale, then arithmetically shifts it right by 16.
  - The value saturates to -32768..32767 and is written to bits 16h+15..16h.
  - Bits 63:32 are zero.
- R8: Expand takes byte i of `rs2_i[31:0]` as an unsigned value, shifts it left by 4, and writes it to bits 16i+15..16i.
- R9: Merge places byte k of `rs2_i` in result byte 2k and byte k of `rs1_i` in result byte 2k+1, for k = 0..3.
- R10: Left shifts by up to 31 never wrap before the clamp. A positive input with a large scale saturates at the top of its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| scale_i | input | 5 | Pack scale factor |
| rs1_i | input | 64 | First operand |
| rs2_i | input | 64 | Second operand |
| vld_o | output | 1 | Result strobe |
| res_o | output | 64 | Registered result |

## Verification
The embedded assertions check the following on every cycle:
- the valid pipeline stage;
- holding of the result while idle;
- zero upper halves for the 32-bit-result packs;
- the low merge byte;
- negative lanes clamping to zero in the byte packs;
- the sign of the fixed pack following its input.

Only the bench's scenarios can show the following:
- the exact clamp and saturation points;
- the ignored top scale bit of the 16-bit pack;
- the overflow-free behaviour at scale 31;
- the results of the undefined codes;
- the asynchronous effect of reset.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned WIDE_W  = 64;

  typedef enum logic [OP_W-1:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pxf_op_e;
endpackage

// File: rtl/pxf_pack8_lane.sv
// Signed fixed-point lane -> unsigned byte with clamp.
module pxf_pack8_lane #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned SC_W = 4,
  parameter int unsigned RSH  = 7
) (
  input  logic [IN_W-1:0] lane_i,
  input  logic [SC_W-1:0] scale_i,
  output logic [7:0]      byte_o
);
  localparam int unsigned WW = pxf_pkg::WIDE_W;

  logic signed [WW-1:0] ext, scaled, shifted;

  always_comb begin
    ext     = {{(WW-IN_W){lane_i[IN_W-1]}}, lane_i};
    scaled  = ext <<< scale_i;
    shifted = scaled >>> RSH;
    if (shifted[WW-1])            byte_o = 8'd0;
    else if (|shifted[WW-2:8])    byte_o = 8'hff;
    else                          byte_o = shifted[7:0];
  end

  always_comb begin
    if (lane_i[IN_W-1]) begin
      // R5 R6
      neg_clamp_chk: assert (byte_o == 8'd0);
    end
  end
endmodule

// File: rtl/pxf_packfix_lane.sv
// Signed 32-bit half -> saturated signed 16-bit field.
module pxf_packfix_lane #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned SC_W  = 5,
  parameter int unsigned RSH   = 16,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  lane_i,
  input  logic [SC_W-1:0]  scale_i,
  output logic [OUT_W-1:0] field_o
);
  localparam int unsigned WW = pxf_pkg::WIDE_W;

  logic signed [WW-1:0] ext, scaled, shifted;
  logic                 in_range;

  always_comb begin
    ext      = {{(WW-IN_W){lane_i[IN_W-1]}}, lane_i};
    scaled   = ext <<< scale_i;
    shifted  = scaled >>> RSH;
    in_range = (&shifted[WW-1:OUT_W-1]) | ~(|shifted[WW-1:OUT_W-1]);
    if (in_range)          field_o = shifted[OUT_W-1:0];
    else if (shifted[WW-1]) field_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                   field_o = {1'b0, {(OUT_W-1){1'b1}}};
  end

  always_comb begin
    // R7
    sign_keep_chk: assert (field_o[OUT_W-1] == lane_i[IN_W-1]
                           || (!lane_i[IN_W-1] && field_o == '0));
  end
endmodule

// File: rtl/pxf_format_unit.sv
module pxf_format_unit
  import pxf_pkg::*;
#(
  parameter int unsigned SCALE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned N16     = DATA_W / 16;
  localparam int unsigned N32     = DATA_W / 32;
  localparam int unsigned NBYTE_H = HALF_W / 8;
  localparam int unsigned SC16_W  = SCALE_W - 1;

  logic [HALF_W-1:0] pk16_res, pkfix_res;
  logic [DATA_W-1:0] pk32_res, exp_res, mrg_res, rs1_shl, nxt_res;
  logic [7:0]        pk32_byte [N32];

  // 16-bit pack lanes
  for (genvar i = 0; i < N16; i++) begin : g_pk16
    pxf_pack8_lane #(.IN_W(16), .SC_W(SC16_W), .RSH(7)) u_lane (
      .lane_i (rs2_i[16*i +: 16]),
      .scale_i(scale_i[SC16_W-1:0]),
      .byte_o (pk16_res[8*i +: 8])
    );
  end

  // 32-bit pack lanes merged over shifted rs1
  assign rs1_shl = rs1_i << 8;
  for (genvar h = 0; h < N32; h++) begin : g_pk32
    pxf_pack8_lane #(.IN_W(32), .SC_W(SCALE_W), .RSH(23)) u_lane (
      .lane_i (rs2_i[32*h +: 32]),
      .scale_i(scale_i),
      .byte_o (pk32_byte[h])
    );
    assign pk32_res[32*h +: 32] = {rs1_shl[32*h+8 +: 24], pk32_byte[h]};
  end

  // fixed 16-bit pack lanes
  for (genvar h = 0; h < N32; h++) begin : g_pkfix
    pxf_packfix_lane #(.IN_W(32), .SC_W(SCALE_W), .RSH(16), .OUT_W(16)) u_lane (
      .lane_i (rs2_i[32*h +: 32]),
      .scale_i(scale_i),
      .field_o(pkfix_res[16*h +: 16])
    );
  end

  // expand and merge
  for (genvar k = 0; k < NBYTE_H; k++) begin : g_bytes
    assign exp_res[16*k +: 16]     = {4'd0, rs2_i[8*k +: 8], 4'd0};
    assign mrg_res[16*k +: 8]      = rs2_i[8*k +: 8];
    assign mrg_res[16*k + 8 +: 8]  = rs1_i[8*k +: 8];
  end

  always_comb begin
    case (pxf_op_e'(op_i))
      OP_PACK16:  nxt_res = {{HALF_W{1'b0}}, pk16_res};
      OP_PACK32:  nxt_res = pk32_res;
      OP_PACKFIX: nxt_res = {{HALF_W{1'b0}}, pkfix_res};
      OP_EXPAND:  nxt_res = exp_res;
      OP_MERGE:   nxt_res = mrg_res;
      default:    nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= nxt_res;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (vld_o == $past(vld_i)));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(vld_i)) |-> $stable(res_o));

  // R5 R7
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(vld_i) &&
     ($past(op_i) == OP_PACK16 || $past(op_i) == OP_PACKFIX))
    |-> (res_o[DATA_W-1:HALF_W] == '0));

  // R9
  merge_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(vld_i) && $past(op_i) == OP_MERGE)
    |-> (res_o[15:0] == {$past(rs1_i[7:0]), $past(rs2_i[7:0])}));
endmodule

// File: tb/pxf_format_unit_tb_top.sv
module pxf_format_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [4:0]  scale_i = '0;
  logic [63:0] rs1_i = '0, rs2_i = '0;
  logic        vld_o;
  logic [63:0] res_o;

  int checks = 0, errors = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] last_res = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pxf_format_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .op_i(op_i),
    .scale_i(scale_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
    .vld_o(vld_o), .res_o(res_o)
  );

  function automatic logic [7:0] clamp8(longint v);
    if (v < 0) return 8'd0;
    if (v > 255) return 8'hff;
    return v[7:0];
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [4:0] sc);
    logic [63:0] r = '0;
    longint v;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
        v = $signed(b[16*i +: 16]);
        v = (v <<< sc[3:0]) >>> 7;
        r[8*i +: 8] = clamp8(v);
      end
      3'd1: begin
        r = (a << 8) & ~64'h000000ff000000ff;
        for (int h = 0; h < 2; h++) begin
          v = $signed(b[32*h +: 32]);
          v = (v <<< sc) >>> 23;
          r[32*h +: 8] = clamp8(v);
        end
      end
      3'd2: for (int h = 0; h < 2; h++) begin
        v = $signed(b[32*h +: 32]);
        v = (v <<< sc) >>> 16;
        if (v < -32768) v = -32768;
        if (v > 32767) v = 32767;
        r[16*h +: 16] = v[15:0];
      end
      3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = {4'd0, b[8*i +: 8], 4'd0};
      3'd4: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = b[8*k +: 8];
        r[16*k + 8 +: 8] = a[8*k +: 8];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                      logic [4:0] sc, string tag = "");
    @(posedge clk_i); #1;
    vld_i = 1'b1; op_i = op; rs1_i = a; rs2_i = b; scale_i = sc;
    exp_q.push_back(model(op, a, b, sc));
    tag_q.push_back(tag == "" ? op_tag(op) : tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      vld_i = 1'b0; op_i = 3'($urandom); scale_i = 5'($urandom);
      rs1_i = {$urandom, $urandom}; rs2_i = {$urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) last_res = '0;
      else if (vld_o) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: actual vld_o 1 expected 0 (no pending item)");
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, res_o, e);
          last_res = e;
        end
      end else begin
        check("R3", res_o, last_res);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", res_o, 64'd0);
    check("R1", {63'd0, vld_o}, 64'd0);
    rst_ni = 1'b1;

    // R5: clamp points, and scale bit 4 ignored
    send(3'd0, 64'h0, {16'h8000, 16'h7fff, 16'h0100, 16'h0080}, 5'd0);
    send(3'd0, 64'h0, {16'h0010, 16'h0020, 16'hfff0, 16'h0008}, 5'h13, "R5");
    send(3'd0, 64'h0, {16'h0010, 16'h0020, 16'hfff0, 16'h0008}, 5'h03, "R5");
    // R6
    send(3'd1, 64'h1122334455667788, 64'h0000_4000_ffff_0000, 5'd4);
    // R10: no wrap at scale 31
    send(3'd1, 64'hdeadbeefcafef00d, 64'h0000_0100_0000_0001, 5'd31, "R10");
    send(3'd2, 64'h0, 64'h4000_0000_0000_0100, 5'd31, "R10");
    // R7: saturation both ends and in-range
    send(3'd2, 64'h0, 64'h8000_0000_7fff_ffff, 5'd1);
    send(3'd2, 64'h0, 64'hfff8_0000_0012_3400, 5'd2);
    // R8, R9
    send(3'd3, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_a5ff_0180, 5'd7);
    send(3'd4, 64'h0102_0304_a1b2_c3d4, 64'h0506_0708_1a2b_3c4d, 5'd0);
    // R4: undefined codes
    send(3'd5, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 5'd9);
    send(3'd6, 64'h1234, 64'h5678, 5'd1);
    send(3'd7, 64'h1, 64'h2, 5'd2);
    idle(4); // R3 hold with toggling inputs

    for (int n = 0; n < 300; n++) begin
      send(3'($urandom % 8), {$urandom, $urandom}, {$urandom, $urandom},
           5'($urandom));
      if (($urandom % 4) == 0) idle(1 + $urandom % 3);
    end
    idle(3);

    // R1: asynchronous clear mid-cycle
    send(3'd4, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 5'd0, "R9");
    @(posedge clk_i); #1;
    vld_i = 1'b1; op_i = 3'd4;
    @(posedge clk_i); #2;
    rst_ni = 1'b0;
    exp_q.delete(); tag_q.delete();
    #1;
    check("R1", res_o, 64'd0);
    check("R1", {63'd0, vld_o}, 64'd0);
    vld_i = 1'b0;
    repeat (2) @(posedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule